// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a clocked single-port memory in which every command is taken on one rising edge and its data moves during the next cycle. Because the data phase trails the command by exactly one cycle, reads and writes can be mixed on consecutive cycles with no idle slot between them. Read data flows straight from the array, addressed by the registered command, with no output register. Write data is presented during the data cycle and is committed at the edge that closes that cycle.

A command is qualified by three chip enables, one active-high and two active-low, and by an advance/load control. When load is requested, a new external address is taken. When advance is requested, an internal two-bit beat counter steps the low address bits in linear or interleaved order and repeats the previous operation type. Four active-low lane selects gate 9-bit byte lanes on writes. An active-low clock enable freezes the whole block, and an asynchronous output enable can switch the read drive off at any moment. Split data-in, data-out and drive-enable ports stand in for a bidirectional bus.

Top module: `zbt_sram`

## Requirements
- R1: After reset no data phase is pending: `rdata_oe` is 0 and `rdata` is 0.
- R2: A command taken on a clock-enabled edge has its data phase in the following cycle. A read drives the word at the registered address combinationally during that cycle. A write stores `wdata` at the edge that ends that cycle.
- R3: Reads and writes may be issued on every cycle in any mix. A read issued right after a write to the same address returns the newly written word.
- R4: While `cke_n` is 1, every other synchronous input is ignored and all state holds. A pending write is not stored until the next edge with `cke_n` low, and a pending read keeps driving its word.
- R5: A new operation starts only when `adv_ld` is 0, `en_a_n` is 0, `en_b` is 1 and `en_c_n` is 0. With `adv_ld` 0 and any enable inactive, the cycle is a deselect.
- R6: A transfer already in its data phase completes when a deselect is issued. `rdata_oe` is 0 in the cycle after a deselect or after a write command.
- R7: With `adv_ld` 1 after an operation, the previous operation type repeats at the next burst address and the upper address bits stay fixed. The beat count wraps after four beats. With `adv_ld` 1 after a deselect, the cycle stays a deselect.
- R8: `order_il` is latched with a load. For beat n (0..3) from loaded low bits s, the low two address bits are (s+n) mod 4 when `order_il` is 0 and s XOR n when `order_il` is 1.
- R9: `lane_wr_n[i]` low enables byte lane i, which is bits [9i+8:9i], for the write beat commanded on that edge. It is sampled on each load and on each burst advance.
- R10: `oe_n` high forces `rdata_oe` to 0 and `rdata` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | 10 | Word address for a load |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cke_n | input | 1 | Clock enable, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| order_il | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data for the current data phase |
| rdata | output | 36 | Read data, 0 when not driving |
| rdata_oe | output | 1 | Read drive enable |

## Verification
The commit of a pending write and the start of a new read can fall on the same edge. The bench provokes this by issuing a read to the same address right after a write, with the write data on the bus. The read in the next cycle must show the new word, per lane. A stalled edge can also land in the middle of a write burst. The bench checks that the write waits for the next enabled edge and takes the data present there. A reference model updated on every edge judges both cases, checking every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int BEAT_W = 2;

    typedef struct packed {
        logic              act;
        logic              rd;
        logic              il;
        logic [BEAT_W-1:0] beat;
    } phase_t;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  logic             il,
    output logic [CNT_W-1:0] lo
);
    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] xor_lo;

    always_comb begin
        lin_lo = start + beat;
        xor_lo = start ^ beat;
        lo     = il ? xor_lo : lin_lo;
    end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lanes_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !lanes_n[g]) begin
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[addr];
    end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              rw,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lanes_n_i,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [LANES-1:0]  ph_lanes_n,
    output logic              ph_rd_act,
    output logic              commit
);
    typedef struct packed {
        phase_t            ph;
        logic [ADDR_W-1:0] base;
        logic [LANES-1:0]  lanes_n;
    } st_t;

    st_t               st_d, st_q;
    logic [BEAT_W-1:0] lo;

    always_comb begin
        st_d = st_q;
        if (!cke_n) begin
            if (!adv_ld) begin
                if (sel) begin
                    st_d.ph.act  = 1'b1;
                    st_d.ph.rd   = rw;
                    st_d.ph.il   = order_il;
                    st_d.ph.beat = '0;
                    st_d.base    = addr;
                    st_d.lanes_n = lanes_n_i;
                end else begin
                    st_d.ph.act = 1'b0;
                end
            end else if (st_q.ph.act) begin
                st_d.ph.beat = st_q.ph.beat + 1'b1;
                st_d.lanes_n = lanes_n_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    zbt_burst_seq #(.CNT_W(BEAT_W)) u_seq (
        .start (st_q.base[BEAT_W-1:0]),
        .beat  (st_q.ph.beat),
        .il    (st_q.ph.il),
        .lo    (lo)
    );

    assign ph_addr    = {st_q.base[ADDR_W-1:BEAT_W], lo};
    assign ph_lanes_n = st_q.lanes_n;
    assign ph_rd_act  = st_q.ph.act && st_q.ph.rd;
    assign commit     = !cke_n && st_q.ph.act && !st_q.ph.rd;

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(st_q));

    // R5
    no_start_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !sel) |=> !st_q.ph.act);

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && st_q.ph.act) |=>
        (ph_addr[ADDR_W-1:BEAT_W] == $past(ph_addr[ADDR_W-1:BEAT_W])) &&
        (st_q.ph.rd == $past(st_q.ph.rd)));

    // R8
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && st_q.ph.act && !st_q.ph.il) |=>
        (ph_addr[BEAT_W-1:0] == $past(ph_addr[BEAT_W-1:0]) + 2'd1));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    rw,
    input  logic                    cke_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    adv_ld,
    input  logic                    order_il,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic              sel;
    logic [ADDR_W-1:0] ph_addr;
    logic [LANES-1:0]  ph_lanes_n;
    logic              ph_rd_act;
    logic              commit;
    logic [DATA_W-1:0] arr_rd;

    assign sel = !en_a_n && en_b && !en_c_n;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n      (cke_n),
        .sel        (sel),
        .adv_ld     (adv_ld),
        .rw         (rw),
        .order_il   (order_il),
        .addr       (addr),
        .lanes_n_i  (lane_wr_n),
        .ph_addr    (ph_addr),
        .ph_lanes_n (ph_lanes_n),
        .ph_rd_act  (ph_rd_act),
        .commit     (commit)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we      (commit),
        .lanes_n (ph_lanes_n),
        .addr    (ph_addr),
        .wdata   (wdata),
        .rdata   (arr_rd)
    );

    assign rdata_oe = ph_rd_act && !oe_n;
    assign rdata    = rdata_oe ? arr_rd : '0;

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && (!sel || !rw)) |=> !rdata_oe);
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
    logic        rw = 1'b1, cke_n = 1'b0, adv_ld = 1'b0, order_il = 1'b0, oe_n = 1'b0;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_oe;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    logic [35:0] mm [0:1023];
    int m_act = 0, m_rd = 0, m_il = 0, m_beat = 0, m_base = 0;
    logic [3:0] m_lanes = 4'hF;

    always #10 clk = ~clk;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .rw(rw), .cke_n(cke_n), .lane_wr_n(lane_wr_n),
        .adv_ld(adv_ld), .order_il(order_il), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [35:0] pat(input int i);
        return 36'h1_2345_6789 + 36'(i) * 36'h0_0301_0507;
    endfunction

    function automatic int maddr();
        int lo;
        if (m_il != 0) lo = (m_base & 3) ^ m_beat;
        else           lo = ((m_base & 3) + m_beat) & 3;
        return (m_base & ~3) | lo;
    endfunction

    task automatic model_edge();
        int a;
        if (cke_n == 1'b0) begin
            if (m_act != 0 && m_rd == 0) begin
                a = maddr();
                for (int i = 0; i < 4; i++)
                    if (!m_lanes[i]) mm[a][9*i +: 9] = wdata[9*i +: 9];
            end
            if (!adv_ld) begin
                if (!en_a_n && en_b && !en_c_n) begin
                    m_act = 1; m_rd = int'(rw); m_il = int'(order_il);
                    m_beat = 0; m_base = int'(addr); m_lanes = lane_wr_n;
                end else begin
                    m_act = 0;
                end
            end else if (m_act != 0) begin
                m_beat = (m_beat + 1) & 3;
                m_lanes = lane_wr_n;
            end
        end
    endtask

    task automatic check_out(input string tag);
        logic        e_oe;
        logic [35:0] e_d;
        e_oe = (m_act != 0) && (m_rd != 0) && !oe_n;
        e_d  = e_oe ? mm[maddr()] : 36'h0;
        checks++;
        if (rdata_oe !== e_oe) begin
            errs++;
            $display("FAIL %s: rdata_oe=%b expected %b", tag, rdata_oe, e_oe);
        end
        checks++;
        if (rdata !== e_d) begin
            errs++;
            $display("FAIL %s: rdata=%h expected %h", tag, rdata, e_d);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic cmd(input logic r, input int a, input logic [3:0] ln, input logic o,
                       input logic [35:0] wd, input string tag);
        cke_n = 0; adv_ld = 0; en_a_n = 0; en_b = 1; en_c_n = 0;
        rw = r; addr = 10'(a); lane_wr_n = ln; order_il = o; wdata = wd;
        tick(tag);
    endtask

    task automatic cont(input logic [3:0] ln, input logic [35:0] wd, input string tag);
        cke_n = 0; adv_ld = 1; lane_wr_n = ln; wdata = wd;
        addr = 10'h3FF; rw = ~rw;
        tick(tag);
    endtask

    task automatic desel(input int which, input logic [35:0] wd, input string tag);
        cke_n = 0; adv_ld = 0; en_a_n = (which == 1); en_b = (which != 2);
        en_c_n = (which == 3); wdata = wd; addr = 10'h3FF; rw = 1;
        tick(tag);
    endtask

    task automatic stall(input logic [35:0] wd, input string tag);
        cke_n = 1; adv_ld = 0; en_a_n = 0; en_b = 1; en_c_n = 0;
        rw = ~rw; addr = 10'h2AA; lane_wr_n = 4'h0; wdata = wd;
        tick(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_out("R1");
        rst_n = 1;
        check_out("R1");

        // R2 fill words 0..31 back to back, then read some back
        for (int i = 0; i < 32; i++) cmd(0, i, 4'h0, 0, pat(i - 1), "R2");
        cmd(1, 0, 4'h0, 0, pat(31), "R2");
        for (int i = 1; i < 4; i++) cmd(1, i, 4'h0, 0, '0, "R2");
        cmd(1, 31, 4'h0, 0, '0, "R2");

        // R3 mixed traffic, read right after write to same word
        cmd(0, 8, 4'h0, 0, '0, "R3");
        cmd(1, 8, 4'h0, 0, pat(100), "R3");
        cmd(0, 9, 4'h0, 0, '0, "R3");
        cmd(1, 9, 4'h0, 0, pat(101), "R3");
        cmd(1, 10, 4'h0, 0, '0, "R3");
        cmd(0, 10, 4'h0, 0, '0, "R3");
        cmd(1, 10, 4'h0, 0, pat(102), "R3");
        desel(1, '0, "R3");

        // R9 partial lanes
        cmd(0, 12, 4'b1010, 0, '0, "R9");
        cmd(1, 12, 4'h0, 0, 36'hF_FFFF_FFFF, "R9");
        cmd(0, 13, 4'b0111, 0, '0, "R9");
        cont(4'b1110, 36'h0_0000_0000, "R9");
        cmd(1, 13, 4'h0, 0, 36'h5_5555_5555, "R9");
        cont(4'h0, '0, "R9");

        // R8 linear write burst from 5, interleaved read back
        cmd(0, 5, 4'h0, 0, '0, "R8");
        cont(4'h0, pat(200), "R8");
        cont(4'h0, pat(201), "R8");
        cont(4'h0, pat(202), "R8");
        cmd(1, 5, 4'h0, 1, pat(203), "R8");
        cont(4'h0, '0, "R8");
        cont(4'h0, '0, "R8");
        cont(4'h0, '0, "R8");
        // R7 wrap beyond four beats
        cont(4'h0, '0, "R7");
        cont(4'h0, '0, "R7");
        cmd(1, 5, 4'h0, 0, '0, "R8");
        cont(4'h0, '0, "R8");
        cont(4'h0, '0, "R8");
        cont(4'h0, '0, "R8");
        cont(4'h0, '0, "R7");

        // R4 stalls in read and write bursts
        cmd(1, 20, 4'h0, 0, '0, "R4");
        cont(4'h0, '0, "R4");
        stall(36'hA_AAAA_AAAA, "R4");
        stall(36'h5_5555_5555, "R4");
        cont(4'h0, '0, "R4");
        cmd(0, 21, 4'h0, 0, '0, "R4");
        stall(36'hB_BBBB_BBBB, "R4");
        cont(4'h0, pat(300), "R4");
        stall(36'hC_CCCC_CCCC, "R4");
        cmd(1, 21, 4'h0, 0, pat(301), "R4");
        cont(4'h0, '0, "R4");

        // R5 R6 deselects and pending completion
        cmd(0, 24, 4'h0, 0, '0, "R6");
        desel(1, pat(400), "R6");
        cont(4'h0, '0, "R7");
        cmd(1, 24, 4'h0, 0, '0, "R5");
        desel(2, '0, "R6");
        cmd(0, 25, 4'h0, 0, '0, "R5");
        desel(3, pat(401), "R5");
        cmd(1, 25, 4'h0, 0, '0, "R5");
        cmd(1, 24, 4'h0, 0, '0, "R5");
        desel(3, '0, "R6");

        // R10 asynchronous output enable
        cmd(1, 25, 4'h0, 0, '0, "R10");
        #2 oe_n = 1;
        #2 check_out("R10");
        #2 oe_n = 0;
        #2 check_out("R10");
        desel(2, '0, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule